// File: doc/BRIEF.md
# High-Bandwidth Transmit Packet Sectioner

This block sits between a transmit endpoint's packet slot and the protocol engine of a high-speed serial bus controller. Software queues one packet by pulsing a packet-ready strobe together with the packet length, the per-transaction payload limit and a multiplier field. The multiplier field holds the number of transactions per microframe minus one. The block holds the packet and emits one section command for every transmit opportunity. Each section command carries a section index, a byte length and a last-section marker. The protocol engine uses these commands to send the data from its FIFO.

Every section except the final one carries a full payload, and the final one carries what is left over. All sections of a packet must leave within a single microframe. In peripheral mode, a new microframe that starts after the first section has gone out means too few IN tokens arrived. In host mode, a missing response from the device to a section has the same meaning. In both cases the block drops the remaining sections, frees the slot and raises a sticky incomplete-transmit flag. The flag stays set until software clears it.

Top module: `hbw_tx_sectioner`

## Requirements
- R1: After a synchronous reset, `pkt_rdy`, `incomp_tx` and `sec_valid` are all low.
- R2: The transaction count comes from `mult_m1`: value 0 gives one transaction, value 1 gives two, and values 2 and 3 give three. The section index `sec_idx` of an issued section is always below 3.
- R3: The effective payload is the smaller of `max_payload` and `MAX_PL` (1024 bytes). No section is longer than this value.
- R4: A `pkt_set` strobe is accepted, and raises `pkt_rdy` one cycle later, only in two cases. No packet may be pending, and `pkt_len` may not exceed the transaction count times the effective payload. Any other `pkt_set` is ignored: `pkt_rdy` and the pending packet stay unchanged.
- R5: Each `in_token` that arrives while a packet is pending gives a one-cycle `sec_valid` pulse on the next cycle. The `sec_idx` values count 0, 1, 2. Every section except the last has the effective payload as its length. The last section carries the remainder and has `sec_last` high. A zero-length packet gives one zero-length section with `sec_last` high.
- R6: `pkt_rdy` falls on the same clock edge that issues the last section.
- R7: A `uframe_start` while a packet is pending with at least one section already issued aborts the packet. On the next cycle `incomp_tx` is high and `pkt_rdy` is low, and the remaining sections are never issued. A `uframe_start` before any section of the packet has gone out has no effect. An `in_token` in the same cycle as `uframe_start` is ignored.
- R8: When `host_mode` is high, a `no_resp` while a packet is pending with at least one section issued aborts the packet in the same way as R7. A `no_resp` in peripheral mode, or before any section has gone out, is ignored.
- R9: `incomp_tx` stays high until an `incomp_clr` pulse. If an abort and a clear happen in the same cycle, the flag ends up set.
- R10: An `in_token` while no packet is pending produces no section.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_set | input | 1 | Software packet-ready strobe |
| pkt_len | input | LEN_W (12) | Packet length in bytes, sampled with `pkt_set` |
| max_payload | input | PL_W (11) | Per-transaction payload limit in bytes |
| mult_m1 | input | 2 | Transactions per microframe minus one |
| host_mode | input | 1 | 1 = host mode, 0 = peripheral mode |
| in_token | input | 1 | Transmit opportunity strobe from the protocol engine |
| uframe_start | input | 1 | Microframe start strobe |
| no_resp | input | 1 | Device gave no response to the last section (host mode) |
| incomp_clr | input | 1 | Software clear of the incomplete-transmit flag |
| sec_valid | output | 1 | One-cycle section command strobe |
| sec_len | output | PL_W (11) | Byte length of the section |
| sec_idx | output | 2 | Section index within the packet |
| sec_last | output | 1 | Marks the final section of the packet |
| pkt_rdy | output | 1 | A packet is pending in the slot |
| incomp_tx | output | 1 | Sticky incomplete-transmit flag |

## Verification
The bench feeds packets whose length is exactly the limit, one byte over the limit, zero, and not a multiple of the payload. A design with an off-by-one limit would accept the overlong packet, and a design that splits wrongly would emit an extra or short section. Microframe starts are placed before the first section, after a partial packet, and in the same cycle as a token. A design that aborts too early would flag a packet that is only waiting, and one that honours the colliding token would issue a section it must discard. A no-response report is sent in both modes, and abort is made to coincide with a software clear. This catches designs that react to the report in peripheral mode or let the clear win. A second packet-ready strobe while a packet is pending, and a payload above 1024 bytes, show whether the slot gets overwritten or the payload cap is ignored.

// File: rtl/hbw_tx_pkg.sv
package hbw_tx_pkg;

  // Maps the multiplier field to the number of transactions per microframe.
  function automatic logic [1:0] xact_count(input logic [1:0] m1);
    case (m1)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/hbw_tx_admit.sv
module hbw_tx_admit #(
  parameter int MAX_PL = 1024,
  parameter int PL_W   = $clog2(MAX_PL + 1),
  parameter int LEN_W  = $clog2(3 * MAX_PL + 1)
) (
  input  logic [PL_W-1:0]  max_payload,
  input  logic [1:0]       mult_m1,
  input  logic [LEN_W-1:0] pkt_len,
  output logic [PL_W-1:0]  maxp_eff,
  output logic             fits
);
  import hbw_tx_pkg::*;

  localparam logic [PL_W-1:0] CAP = PL_W'(MAX_PL);

  logic [LEN_W-1:0] limit;

  always_comb begin
    maxp_eff = (max_payload > CAP) ? CAP : max_payload;
    limit    = LEN_W'(xact_count(mult_m1)) * LEN_W'(maxp_eff);
    fits     = (pkt_len <= limit);
  end

endmodule

// File: rtl/hbw_tx_section_gen.sv
module hbw_tx_section_gen #(
  parameter int MAX_PL = 1024,
  parameter int PL_W   = $clog2(MAX_PL + 1),
  parameter int LEN_W  = $clog2(3 * MAX_PL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] load_len,
  input  logic [PL_W-1:0]  load_maxp,
  input  logic             slot,
  input  logic             abort,
  output logic             busy,
  output logic             started,
  output logic             sec_valid,
  output logic [PL_W-1:0]  sec_len,
  output logic [1:0]       sec_idx,
  output logic             sec_last
);

  logic [LEN_W-1:0] rem;
  logic [PL_W-1:0]  maxp;
  logic [1:0]       idx;
  logic             final_sec;

  assign final_sec = (rem <= LEN_W'(maxp));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      started   <= 1'b0;
      rem       <= '0;
      maxp      <= '0;
      idx       <= '0;
      sec_valid <= 1'b0;
      sec_len   <= '0;
      sec_idx   <= '0;
      sec_last  <= 1'b0;
    end else begin
      sec_valid <= 1'b0;
      if (abort) begin
        busy    <= 1'b0;
        started <= 1'b0;
      end else if (load) begin
        busy    <= 1'b1;
        started <= 1'b0;
        rem     <= load_len;
        maxp    <= load_maxp;
        idx     <= '0;
      end else if (busy && slot) begin
        sec_valid <= 1'b1;
        sec_idx   <= idx;
        sec_last  <= final_sec;
        sec_len   <= final_sec ? rem[PL_W-1:0] : maxp;
        if (final_sec) begin
          busy    <= 1'b0;
          started <= 1'b0;
        end else begin
          rem     <= rem - LEN_W'(maxp);
          idx     <= idx + 2'd1;
          started <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/hbw_tx_incomp.sv
module hbw_tx_incomp (
  input  logic clk,
  input  logic rst,
  input  logic abort,
  input  logic clr,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst)        flag <= 1'b0;
    else if (abort) flag <= 1'b1;
    else if (clr)   flag <= 1'b0;
  end

endmodule

// File: rtl/hbw_tx_sectioner.sv
module hbw_tx_sectioner #(
  parameter int MAX_PL = 1024,
  parameter int PL_W   = $clog2(MAX_PL + 1),
  parameter int LEN_W  = $clog2(3 * MAX_PL + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_set,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic [PL_W-1:0]  max_payload,
  input  logic [1:0]       mult_m1,
  input  logic             host_mode,
  input  logic             in_token,
  input  logic             uframe_start,
  input  logic             no_resp,
  input  logic             incomp_clr,
  output logic             sec_valid,
  output logic [PL_W-1:0]  sec_len,
  output logic [1:0]       sec_idx,
  output logic             sec_last,
  output logic             pkt_rdy,
  output logic             incomp_tx
);

  logic [PL_W-1:0] maxp_eff;
  logic            fits;
  logic            busy;
  logic            started;
  logic            accept;
  logic            abort;
  logic            slot;

  hbw_tx_admit #(.MAX_PL(MAX_PL), .PL_W(PL_W), .LEN_W(LEN_W)) u_admit (
    .max_payload (max_payload),
    .mult_m1     (mult_m1),
    .pkt_len     (pkt_len),
    .maxp_eff    (maxp_eff),
    .fits        (fits)
  );

  // A started packet that meets a new microframe or a missing response is lost.
  assign abort  = busy && started && (uframe_start || (host_mode && no_resp));
  assign accept = pkt_set && !busy && fits;
  assign slot   = in_token && !uframe_start;

  hbw_tx_section_gen #(.MAX_PL(MAX_PL), .PL_W(PL_W), .LEN_W(LEN_W)) u_gen (
    .clk       (clk),
    .rst       (rst),
    .load      (accept),
    .load_len  (pkt_len),
    .load_maxp (maxp_eff),
    .slot      (slot),
    .abort     (abort),
    .busy      (busy),
    .started   (started),
    .sec_valid (sec_valid),
    .sec_len   (sec_len),
    .sec_idx   (sec_idx),
    .sec_last  (sec_last)
  );

  hbw_tx_incomp u_flag (
    .clk   (clk),
    .rst   (rst),
    .abort (abort),
    .clr   (incomp_clr),
    .flag  (incomp_tx)
  );

  assign pkt_rdy = busy;

endmodule

// File: rtl/hbw_tx_sectioner_chk.sv
module hbw_tx_sectioner_chk #(
  parameter int MAX_PL = 1024,
  parameter int PL_W   = $clog2(MAX_PL + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            in_token,
  input logic            incomp_clr,
  input logic            sec_valid,
  input logic [PL_W-1:0] sec_len,
  input logic [1:0]      sec_idx,
  input logic            sec_last,
  input logic            pkt_rdy,
  input logic            incomp_tx
);

  assert_idx_range_R2: assert property (@(posedge clk) disable iff (rst)
    sec_valid |-> (sec_idx < 2'd3));

  assert_len_cap_R3: assert property (@(posedge clk) disable iff (rst)
    sec_valid |-> (sec_len <= PL_W'(MAX_PL)));

  assert_sec_from_pkt_R5: assert property (@(posedge clk) disable iff (rst)
    sec_valid |-> $past(pkt_rdy));

  assert_last_frees_R6: assert property (@(posedge clk) disable iff (rst)
    (sec_valid && sec_last) |-> !pkt_rdy);

  assert_abort_frees_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(incomp_tx) |-> !pkt_rdy);

  assert_flag_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (incomp_tx && !incomp_clr) |=> incomp_tx);

  assert_idle_token_R10: assert property (@(posedge clk) disable iff (rst)
    (!pkt_rdy && in_token) |=> !sec_valid);

endmodule

bind hbw_tx_sectioner hbw_tx_sectioner_chk #(.MAX_PL(MAX_PL), .PL_W(PL_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_token   (in_token),
  .incomp_clr (incomp_clr),
  .sec_valid  (sec_valid),
  .sec_len    (sec_len),
  .sec_idx    (sec_idx),
  .sec_last   (sec_last),
  .pkt_rdy    (pkt_rdy),
  .incomp_tx  (incomp_tx)
);

// File: tb/hbw_tx_sectioner_test.sv
module hbw_tx_sectioner_test;

  localparam int MAX_PL = 1024;
  localparam int PL_W   = $clog2(MAX_PL + 1);
  localparam int LEN_W  = $clog2(3 * MAX_PL + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pkt_set = 1'b0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic [PL_W-1:0]  max_payload = '0;
  logic [1:0]       mult_m1 = '0;
  logic             host_mode = 1'b0;
  logic             in_token = 1'b0;
  logic             uframe_start = 1'b0;
  logic             no_resp = 1'b0;
  logic             incomp_clr = 1'b0;
  logic             sec_valid;
  logic [PL_W-1:0]  sec_len;
  logic [1:0]       sec_idx;
  logic             sec_last;
  logic             pkt_rdy;
  logic             incomp_tx;

  typedef struct {
    int len;
    int idx;
    int last;
  } sec_t;

  sec_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  bit   done = 1'b0;

  always #2 clk = ~clk;

  hbw_tx_sectioner #(.MAX_PL(MAX_PL)) uut (
    .clk (clk), .rst (rst), .pkt_set (pkt_set), .pkt_len (pkt_len),
    .max_payload (max_payload), .mult_m1 (mult_m1), .host_mode (host_mode),
    .in_token (in_token), .uframe_start (uframe_start), .no_resp (no_resp),
    .incomp_clr (incomp_clr), .sec_valid (sec_valid), .sec_len (sec_len),
    .sec_idx (sec_idx), .sec_last (sec_last), .pkt_rdy (pkt_rdy),
    .incomp_tx (incomp_tx)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: compares every issued section against the scoreboard queue.
  always @(negedge clk) begin
    if (!rst && sec_valid) begin
      if (exp_q.size() == 0) begin
        check_eq("R5", "unexpected section len", int'(sec_len), -1);
      end else begin
        sec_t e;
        e = exp_q.pop_front();
        check_eq("R5", "section len", int'(sec_len), e.len);
        check_eq("R5", "section idx", int'(sec_idx), e.idx);
        check_eq("R5", "section last", int'(sec_last), e.last);
      end
    end
  end

  task automatic expect_sec(int len, int idx, int last);
    sec_t e;
    e.len = len; e.idx = idx; e.last = last;
    exp_q.push_back(e);
  endtask

  task automatic load(int len, int maxp, int m1);
    pkt_len = LEN_W'(len); max_payload = PL_W'(maxp); mult_m1 = 2'(m1);
    pkt_set = 1'b1;
    @(negedge clk);
    pkt_set = 1'b0;
  endtask

  task automatic token();
    in_token = 1'b1;
    @(negedge clk);
    in_token = 1'b0;
  endtask

  task automatic uframe();
    uframe_start = 1'b1;
    @(negedge clk);
    uframe_start = 1'b0;
  endtask

  task automatic clear_flag();
    incomp_clr = 1'b1;
    @(negedge clk);
    incomp_clr = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_eq("R1", "pkt_rdy in reset", int'(pkt_rdy), 0);
    check_eq("R1", "incomp_tx in reset", int'(incomp_tx), 0);
    check_eq("R1", "sec_valid in reset", int'(sec_valid), 0);
    rst = 1'b0;
    @(negedge clk);

    // R10: token with nothing pending
    token();
    check_eq("R10", "idle token sec_valid", int'(sec_valid), 0);

    // R5 R6: two sections, remainder last
    load(150, 100, 1);
    check_eq("R4", "accept pkt_rdy", int'(pkt_rdy), 1);
    expect_sec(100, 0, 0); expect_sec(50, 1, 1);
    token();
    check_eq("R6", "pkt_rdy mid packet", int'(pkt_rdy), 1);
    token();
    check_eq("R6", "pkt_rdy after last", int'(pkt_rdy), 0);

    // R2 R4: exact three-section limit, then one byte over
    load(3072, 1024, 2);
    for (int i = 0; i < 3; i++) expect_sec(1024, i, (i == 2) ? 1 : 0);
    repeat (3) token();
    check_eq("R4", "limit packet done", int'(pkt_rdy), 0);
    load(2401, 800, 3);
    check_eq("R4", "overlong rejected", int'(pkt_rdy), 0);
    token();
    check_eq("R4", "no section after reject", int'(sec_valid), 0);
    load(2400, 800, 3);
    for (int i = 0; i < 3; i++) expect_sec(800, i, (i == 2) ? 1 : 0);
    repeat (3) token();

    // R2: one transaction per microframe
    load(65, 64, 0);
    check_eq("R2", "single-xact overlong rejected", int'(pkt_rdy), 0);
    load(64, 64, 0);
    expect_sec(64, 0, 1);
    token();

    // R5: zero-length packet
    load(0, 64, 0);
    expect_sec(0, 0, 1);
    token();
    check_eq("R5", "zero-length done", int'(pkt_rdy), 0);

    // R3: payload capped at 1024
    load(2048, 2000, 1);
    check_eq("R3", "clamped accept", int'(pkt_rdy), 1);
    expect_sec(1024, 0, 0); expect_sec(1024, 1, 1);
    repeat (2) token();

    // R4: second set while pending ignored
    load(150, 100, 1);
    load(30, 100, 0);
    check_eq("R4", "pending kept", int'(pkt_rdy), 1);
    expect_sec(100, 0, 0); expect_sec(50, 1, 1);
    repeat (2) token();

    // R7: microframe before any section waits
    load(100, 100, 0);
    uframe();
    check_eq("R7", "unstarted no flag", int'(incomp_tx), 0);
    check_eq("R7", "unstarted still pending", int'(pkt_rdy), 1);
    expect_sec(100, 0, 1);
    token();

    // R7 R9: partial packet aborted by new microframe
    load(250, 100, 2);
    expect_sec(100, 0, 0);
    token();
    uframe();
    check_eq("R7", "abort sets flag", int'(incomp_tx), 1);
    check_eq("R7", "abort frees slot", int'(pkt_rdy), 0);
    token();
    check_eq("R7", "discarded section", int'(sec_valid), 0);
    repeat (3) @(negedge clk);
    check_eq("R9", "flag sticky", int'(incomp_tx), 1);
    clear_flag();
    check_eq("R9", "flag cleared", int'(incomp_tx), 0);

    // R7: token colliding with microframe start is ignored
    load(200, 100, 1);
    expect_sec(100, 0, 0);
    token();
    in_token = 1'b1; uframe_start = 1'b1;
    @(negedge clk);
    in_token = 1'b0; uframe_start = 1'b0;
    check_eq("R7", "collide no section", int'(sec_valid), 0);
    check_eq("R7", "collide flag", int'(incomp_tx), 1);

    // R9: abort and clear together leave flag set
    clear_flag();
    load(200, 100, 1);
    expect_sec(100, 0, 0);
    token();
    uframe_start = 1'b1; incomp_clr = 1'b1;
    @(negedge clk);
    uframe_start = 1'b0; incomp_clr = 1'b0;
    check_eq("R9", "set beats clear", int'(incomp_tx), 1);
    clear_flag();

    // R8: host-mode no response aborts
    host_mode = 1'b1;
    load(300, 100, 2);
    no_resp = 1'b1; @(negedge clk); no_resp = 1'b0;
    check_eq("R8", "no_resp before section ignored", int'(pkt_rdy), 1);
    expect_sec(100, 0, 0);
    token();
    no_resp = 1'b1; @(negedge clk); no_resp = 1'b0;
    check_eq("R8", "host abort flag", int'(incomp_tx), 1);
    check_eq("R8", "host abort frees", int'(pkt_rdy), 0);
    clear_flag();

    // R8: no_resp ignored in peripheral mode
    host_mode = 1'b0;
    load(200, 100, 1);
    expect_sec(100, 0, 0);
    token();
    no_resp = 1'b1; @(negedge clk); no_resp = 1'b0;
    check_eq("R8", "peripheral no_resp flag", int'(incomp_tx), 0);
    check_eq("R8", "peripheral no_resp pending", int'(pkt_rdy), 1);
    expect_sec(100, 1, 1);
    token();

    repeat (2) @(negedge clk);
    check_eq("R5", "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule